// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a down-counting interval timer for a processor's register space. A short prescale counter counts down once on every clock. When it runs out, it reloads itself from a programmable reload value and moves a wider main counter down by one. When the main counter runs out, it reloads from a period register and raises a one-cycle interrupt request. An interrupt controller elsewhere masks and latches the request.

Software reaches the timer through a single-cycle register port. One address holds the main counter and one holds the period. A third address is a control word that packs the live prescale count and its reload value. Writing a command bit in the control word restarts both counters at once. Writes take effect at the next clock edge. Reads are combinational.

Top module: `ivl_timer`

## Requirements
- R1: After reset the main counter and the period both read all ones (0xFFFF), the control word reads 0 and irq is low.
- R2: On every clock the prescaler decrements. If its value is 1 or 0 before the edge, it reloads from the reload field instead, and the main counter steps down by one on that edge.
- R3: If the main counter is 1 or 0 when it steps, it reloads from the period register instead. irq is then high for exactly the cycle in which the counter first shows the reloaded value.
- R4: Address 0 selects the main counter, 1 the period and 2 the control word. Address 3 reads as 0, and writes to it change nothing.
- R5: A control read returns the live prescaler in bits 9:6 and the reload value in bits 3:0. All other bits, bit 5 included, read as 0.
- R6: A control write loads the reload value from bits 3:0 and the prescaler from bits 9:6.
- R7: A control write with bit 5 set loads the main counter from the period and the prescaler from the newly written reload value, overriding bits 9:6. It does not raise irq.
- R8: A write to the counter or period address replaces that register at the same clock edge.
- R9: A write has priority over the tick update of the register it targets, and registers that are not written keep ticking. A counter write on an edge where the counter would have reloaded suppresses irq.
- R10: With period P and reload R (both programmed nonzero), irq recurs every P*R clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; each rising edge is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | One-cycle timer interrupt request |

## Verification
The bench uses the default parameters: a 16-bit data word and counter, and a 4-bit prescaler with its fields at bits 9:6 and 3:0. With the 4-bit prescaler, the all-ones field value 15 and the fast reload-0 mode can be reached within a few cycles. The small periods used (3, 5 and 10) put several full reload cycles and irq pulses within a short run. The 16-bit counter lets the bench confirm that the upper bits of the control word stay zero while the counter holds values above 0xFF.

// File: rtl/ivl_timer_pkg.sv
`timescale 1ns/100ps
package ivl_timer_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      SEL_COUNT  = 2'd0,
      SEL_PERIOD = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_SPARE  = 2'd3
   } sel_e;
endpackage

// File: rtl/ivl_prescale.sv
`timescale 1ns/100ps
module ivl_prescale #(
   parameter int PSC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             restart,
   input  logic [PSC_W-1:0] ld_cnt,
   input  logic [PSC_W-1:0] ld_rel,
   output logic [PSC_W-1:0] cnt,
   output logic [PSC_W-1:0] rel,
   output logic             expire
);
   logic [PSC_W-1:0] cnt_q, rel_q;

   // exhausted when the decremented value would be zero or below
   assign expire = (cnt_q <= PSC_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= '0;
      end else if (load) begin
         rel_q <= ld_rel;
         cnt_q <= restart ? ld_rel : ld_cnt;
      end else if (expire) begin
         cnt_q <= rel_q;
      end else begin
         cnt_q <= cnt_q - PSC_W'(1);
      end
   end

   assign cnt = cnt_q;
   assign rel = rel_q;
endmodule

// File: rtl/ivl_count.sv
`timescale 1ns/100ps
module ivl_count #(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] CNT_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wr_cnt,
   input  logic             wr_per,
   input  logic             restart,
   input  logic [CNT_W-1:0] wval,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] per,
   output logic             irq
);
   logic [CNT_W-1:0] cnt_q, per_q;
   logic             irq_q;
   logic             wrap;

   assign wrap = step && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= CNT_RST;
      end else if (wr_per) begin
         per_q <= wval;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_RST;
         irq_q <= 1'b0;
      end else begin
         irq_q <= wrap && !wr_cnt && !restart;
         if (restart)      cnt_q <= per_q;
         else if (wr_cnt)  cnt_q <= wval;
         else if (wrap)    cnt_q <= per_q;
         else if (step)    cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign cnt = cnt_q;
   assign per = per_q;
   assign irq = irq_q;
endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/100ps
module ivl_timer #(
   parameter int               DATA_W    = 16,
   parameter int               CNT_W     = 16,
   parameter int               PSC_W     = 4,
   parameter int               PSC_LSB   = 6,
   parameter int               FORCE_BIT = 5,
   parameter logic [CNT_W-1:0] CNT_RST   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   import ivl_timer_pkg::*;

   localparam int PSC_MSB = PSC_LSB + PSC_W - 1;

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("ivl_timer: CNT_W must not exceed DATA_W");
   end
   if (PSC_MSB >= DATA_W) begin : g_bad_psc
      $error("ivl_timer: prescale field does not fit the data word");
   end
   if (FORCE_BIT < PSC_W || FORCE_BIT >= PSC_LSB) begin : g_bad_force
      $error("ivl_timer: restart bit overlaps a prescale field");
   end

   sel_e             sel;
   logic             wr_cnt, wr_per, wr_ctl, restart;
   logic [CNT_W-1:0] wval, cnt_q, per_q;
   logic [PSC_W-1:0] psc_q, rel_q;
   logic             psc_exp;

   assign sel     = sel_e'(addr);
   assign wr_cnt  = wr_en && (sel == SEL_COUNT);
   assign wr_per  = wr_en && (sel == SEL_PERIOD);
   assign wr_ctl  = wr_en && (sel == SEL_CTRL);
   assign restart = wr_ctl && wdata[FORCE_BIT];

   if (CNT_W == DATA_W) begin : g_full_width
      assign wval = wdata;
   end else begin : g_narrow
      assign wval = wdata[CNT_W-1:0];
   end

   ivl_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_ctl),
      .restart (restart),
      .ld_cnt  (wdata[PSC_MSB:PSC_LSB]),
      .ld_rel  (wdata[PSC_W-1:0]),
      .cnt     (psc_q),
      .rel     (rel_q),
      .expire  (psc_exp)
   );

   ivl_count #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (psc_exp),
      .wr_cnt  (wr_cnt),
      .wr_per  (wr_per),
      .restart (restart),
      .wval    (wval),
      .cnt     (cnt_q),
      .per     (per_q),
      .irq     (irq)
   );

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_COUNT:  rdata = DATA_W'(cnt_q);
         SEL_PERIOD: rdata = DATA_W'(per_q);
         SEL_CTRL: begin
            rdata[PSC_MSB:PSC_LSB] = psc_q;
            rdata[PSC_W-1:0]       = rel_q;
         end
         SEL_SPARE:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/ivl_timer_chk.sv
`timescale 1ns/100ps
module ivl_timer_chk #(
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter int PSC_W     = 4,
   parameter int FORCE_BIT = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  per_q,
   input logic [PSC_W-1:0]  psc_q
);
   a_r3_irq_shows_period: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt_q == $past(per_q)));

   a_r8_count_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0) |=> (cnt_q == $past(wdata[CNT_W-1:0])) && !irq);

   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd2 && wdata[FORCE_BIT]) |=>
         (cnt_q == $past(per_q)) && (psc_q == $past(wdata[PSC_W-1:0])) && !irq);

   a_r2_prescale_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && addr == 2'd2) && psc_q > PSC_W'(1)) |=>
         (psc_q == $past(psc_q) - PSC_W'(1)));

   a_r5_ctrl_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd2) |-> (rdata[FORCE_BIT] == 1'b0));

   a_r4_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd3) |-> (rdata == '0));
endmodule

bind ivl_timer ivl_timer_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .FORCE_BIT(FORCE_BIT)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .addr  (addr),
   .wdata (wdata),
   .rdata (rdata),
   .irq   (irq),
   .cnt_q (cnt_q),
   .per_q (per_q),
   .psc_q (psc_q)
);

// File: tb/ivl_timer_tb_top.sv
`timescale 1ns/100ps
module ivl_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic        irq;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ivl_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  a;
      logic [15:0] d;
      logic [7:0]  n;
      logic [1:0]  ra;
      logic [15:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd1, 16'h0005, 8'd0, 2'd1, 16'h0005, 4'd8},  // R8 period write
      '{1'b1, 2'd2, 16'h0023, 8'd0, 2'd2, 16'h00C3, 4'd7},  // R7 restart, reload 3
      '{1'b0, 2'd0, 16'h0000, 8'd2, 2'd2, 16'h0043, 4'd2},  // R2 prescaler 3->1
      '{1'b0, 2'd0, 16'h0000, 8'd1, 2'd0, 16'h0004, 4'd2},  // R2 counter steps
      '{1'b0, 2'd0, 16'h0000, 8'd9, 2'd0, 16'h0001, 4'd2},
      '{1'b0, 2'd0, 16'h0000, 8'd3, 2'd0, 16'h0005, 4'd3},  // R3 reload from period
      '{1'b1, 2'd0, 16'h0002, 8'd0, 2'd0, 16'h0002, 4'd8},  // R8 counter write
      '{1'b0, 2'd0, 16'h0000, 8'd2, 2'd0, 16'h0001, 4'd2},
      '{1'b1, 2'd2, 16'h0081, 8'd0, 2'd2, 16'h0081, 4'd6},  // R6 fields loaded
      '{1'b0, 2'd0, 16'h0000, 8'd1, 2'd2, 16'h0041, 4'd5},  // R5 live prescaler
      '{1'b0, 2'd0, 16'h0000, 8'd1, 2'd0, 16'h0005, 4'd3},
      '{1'b0, 2'd0, 16'h0000, 8'd2, 2'd0, 16'h0003, 4'd2},
      '{1'b1, 2'd1, 16'h0100, 8'd0, 2'd1, 16'h0100, 4'd8},
      '{1'b0, 2'd0, 16'h0000, 8'd0, 2'd0, 16'h0002, 4'd9},  // R9 counter ticked during period write
      '{1'b1, 2'd2, 16'h0020, 8'd0, 2'd0, 16'h0100, 4'd7},
      '{1'b0, 2'd0, 16'h0000, 8'd0, 2'd2, 16'h0000, 4'd5},
      '{1'b0, 2'd0, 16'h0000, 8'd4, 2'd0, 16'h00FC, 4'd2},  // reload 0: step each clock
      '{1'b1, 2'd2, 16'hFFDF, 8'd0, 2'd2, 16'h03CF, 4'd6},  // R6 all-ones fields, R5 others zero
      '{1'b0, 2'd0, 16'h0000, 8'd0, 2'd0, 16'h00FB, 4'd9}   // R9 counter stepped on control write
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      addr = a; #0.1;
      v = rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   initial begin
      logic [15:0] v;
      int first_k;
      int irq_cnt;
      int bad;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R1 reset values
      rd(2'd0, v); chk("R1 counter", v, 16'hFFFF);
      rd(2'd1, v); chk("R1 period", v, 16'hFFFF);
      rd(2'd2, v); chk("R1 control", v, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'h0000);

      for (int k = 0; k < NV; k++) begin
         if (VECS[k].wr) wr(VECS[k].a, VECS[k].d);
         idle(int'(VECS[k].n));
         rd(VECS[k].ra, v);
         chk($sformatf("R%0d vector %0d", VECS[k].req, k), v, VECS[k].exp);
      end

      // R4 spare address: write ignored, reads zero
      wr(2'd3, 16'h0020);
      rd(2'd0, v); chk("R4 counter untouched", v, 16'h00FB);
      rd(2'd2, v); chk("R4 reload untouched", {12'd0, v[3:0]}, 16'h000F);
      rd(2'd3, v); chk("R4 spare reads zero", v, 16'h0000);

      // R10 / R3: period 3, reload 2 -> pulse every 6 clocks
      wr(2'd1, 16'h0003);
      wr(2'd2, 16'h0022);
      addr = 2'd0;
      first_k = 0; irq_cnt = 0; bad = 0;
      for (int k = 1; k <= 18; k++) begin
         @(negedge clk); #1;
         if (irq) begin
            irq_cnt++;
            if (first_k == 0) first_k = k;
            if (rdata != 16'h0003) bad++;
         end
         if (irq != (k % 6 == 0)) bad++;
      end
      chk("R10 first irq clock", 16'(first_k), 16'd6);
      chk("R10 irq count", 16'(irq_cnt), 16'd3);
      chk("R3 irq single cycle with reload", 16'(bad), 16'd0);

      // R9: counter write on a reload edge suppresses irq
      wr(2'd1, 16'h000A);
      wr(2'd2, 16'h0020);
      idle(9);
      rd(2'd0, v); chk("R9 pre-wrap counter", v, 16'h0001);
      wr(2'd0, 16'h0007);
      chk("R9 irq suppressed", {15'd0, irq}, 16'h0000);
      rd(2'd0, v); chk("R9 counter written", v, 16'h0007);
      idle(6);
      chk("R3 no irq before wrap", {15'd0, irq}, 16'h0000);
      idle(1);
      chk("R3 irq on wrap", {15'd0, irq}, 16'h0001);
      rd(2'd0, v); chk("R3 reload value", v, 16'h000A);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule